// File: doc/BRIEF.md
# Quarter-Phase Bus Clock Generator with Ready Stretching

This block produces the two quadrature bus clocks, E and Q, of a synchronous processor bus from a timing base that runs at four times the bus rate. Every rising edge of the base clock is a quarter boundary. A normal bus cycle has four quarters: both clocks low, then Q high, then both high, then E alone high. With a 2 MHz bus each quarter lasts 125 ns and a normal cycle lasts 500 ns.

Slow devices ask for a longer cycle by pulling a shared active-low memory-ready line. The generator samples the combined ready only on quarter boundaries. It stays in the "both high" quarter while ready is sampled low, so a stretch always adds a whole number of quarters. Once ready is sampled high, one final quarter with E alone high follows, and then E falls.

The block also contains the requester side. There are two counted ready timers. The first serves slow I/O: its decoded select counts only while the slow-peripheral mode input is set. The second serves a disk controller and is not gated by the mode. At the quarter boundary where E rises, each qualified timer loads its programmed quarter count. It holds the bus ready output low for exactly that many quarters. The external ready input is wire-ANDed with both timers.

Top module: `qclk_stretch`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the first quarter with `e_clk` and `q_clk` low, and clears both timers so `mrdy_n` is high.
- R2: Without a stretch, a cycle is 4 quarters. Quarter 0 has E=0,Q=0; quarter 1 has E=0,Q=1; quarter 2 has E=1,Q=1; quarter 3 has E=1,Q=0. Q therefore rises one quarter before E.
- R3: While the combined ready (`ext_rdy_n` AND `mrdy_n`) is sampled low at the end of an E=1,Q=1 quarter, that quarter repeats. When ready is sampled high, exactly one E=1,Q=0 quarter follows. With a longest low time of M quarters from E rise, E stays high for M+2 quarters and the cycle lasts M+4 quarters.
- R4: Every cycle, stretched or not, ends with exactly one quarter of E=1,Q=0, and Q stays high for as long as E is held.
- R5: With `slow_mode`=1 and `slow_io_sel`=1 sampled in the quarter before E rises, `mrdy_n` goes low as E rises and stays low for exactly `slow_quarters` quarters.
- R6: With `slow_mode`=0, or with neither select set, `mrdy_n` stays high and the cycle is 4 quarters (when the external ready is also high).
- R7: `disk_sel` sampled in the quarter before E rises drives `mrdy_n` low for exactly `disk_quarters` quarters, whatever the value of `slow_mode`.
- R8: When both timers are loaded in one cycle, `mrdy_n` stays low for the larger of the two counts.
- R9: The external ready is ignored in the quarters before E rises and in the final quarter. When it is held low during E-high quarters, it lengthens the cycle as in R3 but does not change `mrdy_n`.
- R10: A programmed count of 0 does not assert `mrdy_n` and does not stretch the cycle.
- R11: A slow count of 6 gives a 10-quarter (1250 ns) cycle, with the combined ready sampled high at the boundary one quarter before E falls. A disk count of 5 gives a 9-quarter (1125 ns) cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate timing base; each rising edge is a quarter boundary |
| rst | input | 1 | Synchronous active-high reset |
| ext_rdy_n | input | 1 | Active-low ready from other bus devices, synchronous to `clk` |
| slow_mode | input | 1 | 1 = slow-peripheral mode, which lets the slow I/O timer act |
| slow_io_sel | input | 1 | Decoded select for a slow I/O access |
| disk_sel | input | 1 | Decoded select for a disk controller access |
| slow_quarters | input | CNT_W | Quarters of ready-low for slow I/O |
| disk_quarters | input | CNT_W | Quarters of ready-low for the disk controller |
| e_clk | output | 1 | Bus E clock |
| q_clk | output | 1 | Bus Q clock, leading E by one quarter |
| mrdy_n | output | 1 | Active-low ready driven by the internal timers |

## Verification
The bench targets four kinds of error.

- **Off-by-one stretch length.** The length of a stretch is where a wrong design usually slips. If ready were sampled one boundary late or early, or if the final E-only quarter were dropped, every stretched cycle would be one quarter too long or too short. The directed cases with counts 6 and 5 would then miss 10 and 9 quarters.
- **Timer gating.** Cycles in normal mode, cycles without a select, and cycles with a count of zero check that no timer fires. A wrong mode gate would stretch normal-mode slow accesses, or would block the disk timer.
- **Overlapping requesters.** Cycles where both timers load at once show whether the wire-AND of the two ready lines is kept. If it is not, the cycle ends with the shorter count.
- **External ready outside the E-high window.** External ready is pulled low before E rises, where it must be ignored. A design that reacted there would hold the wrong phase.

// File: rtl/qclk_pkg.sv
package qclk_pkg;

  // Quarter phases in bus order; the order is behaviour (Q leads E).
  typedef enum logic [1:0] {
    QP_LEAD  = 2'd0,  // E=0 Q=0
    QP_QRISE = 2'd1,  // E=0 Q=1
    QP_EHIGH = 2'd2,  // E=1 Q=1, repeated while ready is low
    QP_ETAIL = 2'd3   // E=1 Q=0, always exactly one quarter
  } qphase_t;

  function automatic logic e_level(qphase_t ph);
    return (ph == QP_EHIGH) || (ph == QP_ETAIL);
  endfunction

  function automatic logic q_level(qphase_t ph);
    return (ph == QP_QRISE) || (ph == QP_EHIGH);
  endfunction

  // Next quarter; hold_n low keeps the sequence in the E-high quarter.
  function automatic qphase_t phase_after(qphase_t ph, logic hold_n);
    qphase_t nx;
    case (ph)
      QP_LEAD:  nx = QP_QRISE;
      QP_QRISE: nx = QP_EHIGH;
      QP_EHIGH: nx = hold_n ? QP_ETAIL : QP_EHIGH;
      default:  nx = QP_LEAD;
    endcase
    return nx;
  endfunction

  // Timer step: load has priority, otherwise count down to zero.
  function automatic logic [15:0] timer_step(logic [15:0] cur, logic load,
                                             logic [15:0] val);
    logic [15:0] nx;
    if (load)            nx = val;
    else if (cur != '0)  nx = cur - 16'd1;
    else                 nx = cur;
    return nx;
  endfunction

endpackage

// File: rtl/qclk_seq.sv
module qclk_seq
  import qclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rdy_any_n,
  output qphase_t phase,
  output logic    e_clk,
  output logic    q_clk,
  output logic    e_start
);

  qphase_t phase_nx;

  always_comb phase_nx = phase_after(phase, rdy_any_n);

  // E rises at the boundary that ends the Q-rise quarter.
  assign e_start = (phase == QP_QRISE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= QP_LEAD;
      e_clk <= 1'b0;
      q_clk <= 1'b0;
    end else begin
      phase <= phase_nx;
      e_clk <= e_level(phase_nx);
      q_clk <= q_level(phase_nx);
    end
  end

endmodule

// File: rtl/qclk_req_timer.sv
module qclk_req_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             rdy_n,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;
  logic [15:0]      step_nx;

  always_comb step_nx = qclk_pkg::timer_step(16'(cnt), load, 16'(load_val));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= step_nx[CNT_W-1:0];
  end

  assign busy  = (cnt != '0);
  assign rdy_n = ~busy;

endmodule

// File: rtl/qclk_stretch.sv
module qclk_stretch
  import qclk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rdy_n,
  input  logic             slow_mode,
  input  logic             slow_io_sel,
  input  logic             disk_sel,
  input  logic [CNT_W-1:0] slow_quarters,
  input  logic [CNT_W-1:0] disk_quarters,
  output logic             e_clk,
  output logic             q_clk,
  output logic             mrdy_n
);

  localparam int NREQ = 2;  // 0: slow I/O, 1: disk controller

  qphase_t          phase;
  logic             e_start;
  logic             rdy_any_n;
  logic [NREQ-1:0]  req_qual;
  logic [NREQ-1:0]  req_load;
  logic [NREQ-1:0]  req_rdy_n;
  logic [NREQ-1:0]  req_busy;
  logic [CNT_W-1:0] req_val [NREQ];

  assign req_qual[0] = slow_mode & slow_io_sel;
  assign req_qual[1] = disk_sel;
  assign req_val[0]  = slow_quarters;
  assign req_val[1]  = disk_quarters;

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_req
      assign req_load[i] = e_start & req_qual[i];
      qclk_req_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (req_load[i]),
        .load_val (req_val[i]),
        .rdy_n    (req_rdy_n[i]),
        .busy     (req_busy[i])
      );
    end
  endgenerate

  // Wired-AND of the requesters on the bus line, then with outside devices.
  assign mrdy_n    = &req_rdy_n;
  assign rdy_any_n = mrdy_n & ext_rdy_n;

  qclk_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .rdy_any_n (rdy_any_n),
    .phase     (phase),
    .e_clk     (e_clk),
    .q_clk     (q_clk),
    .e_start   (e_start)
  );

endmodule

// File: rtl/qclk_stretch_chk.sv
module qclk_stretch_chk (
  input logic clk,
  input logic rst,
  input logic e_clk,
  input logic q_clk,
  input logic mrdy_n,
  input logic rdy_any_n,
  input logic slow_mode,
  input logic slow_io_sel,
  input logic disk_sel
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!e_clk && !q_clk && mrdy_n));

  assert_q_leads_e_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(e_clk) |-> ($past(q_clk) && q_clk));

  assert_hold_while_low_R3: assert property (@(posedge clk) disable iff (rst)
    (e_clk && q_clk && !rdy_any_n) |=> (e_clk && q_clk));

  assert_release_tail_R3: assert property (@(posedge clk) disable iff (rst)
    (e_clk && q_clk && rdy_any_n) |=> (e_clk && !q_clk));

  assert_single_tail_R4: assert property (@(posedge clk) disable iff (rst)
    (e_clk && !q_clk) |=> (!e_clk && !q_clk));

  assert_no_request_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(e_clk) && !$past(disk_sel) && !($past(slow_mode) && $past(slow_io_sel)))
      |-> mrdy_n);

  assert_request_at_e_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(mrdy_n) |-> $rose(e_clk));

endmodule

bind qclk_stretch qclk_stretch_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .e_clk       (e_clk),
  .q_clk       (q_clk),
  .mrdy_n      (mrdy_n),
  .rdy_any_n   (rdy_any_n),
  .slow_mode   (slow_mode),
  .slow_io_sel (slow_io_sel),
  .disk_sel    (disk_sel)
);

// File: tb/qclk_stretch_tb.sv
module qclk_stretch_tb;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ext_rdy_n = 1'b1;
  logic             slow_mode = 1'b0;
  logic             slow_io_sel = 1'b0;
  logic             disk_sel = 1'b0;
  logic [CNT_W-1:0] slow_quarters = '0;
  logic [CNT_W-1:0] disk_quarters = '0;
  logic             e_clk, q_clk, mrdy_n;

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  qclk_stretch #(.CNT_W(CNT_W)) u_dut (
    .clk (clk), .rst (rst), .ext_rdy_n (ext_rdy_n),
    .slow_mode (slow_mode), .slow_io_sel (slow_io_sel), .disk_sel (disk_sel),
    .slow_quarters (slow_quarters), .disk_quarters (disk_quarters),
    .e_clk (e_clk), .q_clk (q_clk), .mrdy_n (mrdy_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Quarters of internal ready-low the requirements call for.
  function automatic int want_req(bit md, bit ss, bit ds, int sq, int dq);
    int a = (md && ss) ? sq : 0;
    int b = ds ? dq : 0;
    return (a > b) ? a : b;
  endfunction

  function automatic int want_hold(int req, int ext_low);
    return (req > ext_low) ? req : ext_low;
  endfunction

  // Called at a falling edge inside the first quarter of a cycle.
  task automatic run_cycle(input string tag, input bit md, input bit ss,
                           input bit ds, input int sq, input int dq,
                           input bit pre_low, input int x);
    int tot = 0, eh = 0, qh = 0, ml = 0, tail = 0, j = 0;
    int n, m;
    bit done = 0;
    slow_mode = md; slow_io_sel = ss; disk_sel = ds;
    slow_quarters = CNT_W'(sq); disk_quarters = CNT_W'(dq);
    ext_rdy_n = ~pre_low;
    chk({tag, " R2 first quarter E,Q"}, {e_clk, q_clk}, 0);
    while (!done) begin
      tot++;
      if (e_clk) eh++;
      if (q_clk) qh++;
      if (!mrdy_n) ml++;
      if (e_clk && !q_clk) begin tail++; done = 1; end
      if (e_clk) begin
        ext_rdy_n = (j < x) ? 1'b0 : 1'b1;
        j++;
      end
      if (tot > 64) done = 1;
      if (!done) @(negedge clk);
    end
    ext_rdy_n = 1'b1;
    n = want_req(md, ss, ds, sq, dq);
    m = want_hold(n, x);
    chk({tag, " R3 cycle quarters"}, tot, m + 4);
    chk({tag, " R3 E high quarters"}, eh, m + 2);
    chk({tag, " R4 Q high quarters"}, qh, m + 2);
    chk({tag, " R4 tail quarters"}, tail, 1);
    chk({tag, " ready low quarters"}, ml, n);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h51ED_0C1C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset E", e_clk, 0);
    chk("R1 reset Q", q_clk, 0);
    chk("R1 reset ready", mrdy_n, 1);
    run_cycle("R2 normal",            0, 0, 0, 0, 0, 0, 0);
    run_cycle("R6 normal mode sel",   0, 1, 0, 7, 0, 0, 0);
    run_cycle("R6 slow mode no sel",  1, 0, 0, 7, 0, 0, 0);
    run_cycle("R5 slow count 3",      1, 1, 0, 3, 9, 0, 0);
    run_cycle("R11 slow 1250ns",      1, 1, 0, 6, 0, 0, 0);
    run_cycle("R11 disk 1125ns",      0, 0, 1, 0, 5, 0, 0);
    run_cycle("R7 disk normal mode",  0, 1, 1, 9, 2, 0, 0);
    run_cycle("R8 both slow longer",  1, 1, 1, 8, 3, 0, 0);
    run_cycle("R8 both disk longer",  1, 1, 1, 2, 11, 0, 0);
    run_cycle("R10 zero slow",        1, 1, 0, 0, 0, 0, 0);
    run_cycle("R10 zero disk",        0, 0, 1, 0, 0, 0, 0);
    run_cycle("R9 ext before E",      0, 0, 0, 0, 0, 1, 0);
    run_cycle("R9 ext during E",      0, 0, 0, 0, 0, 0, 4);
    run_cycle("R9 ext beyond timer",  1, 1, 0, 2, 0, 1, 5);
    run_cycle("R5 slow max",          1, 1, 0, 15, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      bit md = 1'($urandom_range(0, 1));
      bit ss = 1'($urandom_range(0, 1));
      bit ds = 1'($urandom_range(0, 1));
      int sq = $urandom_range(0, 15);
      int dq = $urandom_range(0, 15);
      bit pl = 1'($urandom_range(0, 1));
      int x  = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 8) : 0;
      run_cycle("R3 random", md, ss, ds, sq, dq, pl, x);
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      nvec++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule